// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block is the arithmetic core of a small 16-bit signal processor. It keeps two 16-bit multiplier operand registers, a 32-bit product, a 32-bit accumulator and four status flags. The product is always the signed product of the two operand registers, doubled so that it follows the fractional number format. Each accepted operation takes one clock. It can do any one of these:

- a multiply step;
- an add, subtract, compare or bitwise operation on the accumulator;
- a one-step accumulator modifier;
- a load of the accumulator.

An instruction decoder sends one operation per cycle. Each operation carries a 4-bit opcode, a 2-bit source selector, a 16-bit data word and two multiplier operands. The decoder marks the operation with `op_valid`. Branch logic uses `cond_true` to test the current flags with a condition selector and a polarity bit. This output is purely combinational.

Multiply-add and multiply-subtract fold the product that is already held into the accumulator. In the same operation they load new operands, so the next product is ready on the following cycle. This makes a filter tap cost one operation.

Top module: `fxmac_datapath`

## Requirements
- R1: After reset the accumulator, the product and the status word are all zero.
- R2: The product output equals the signed product of the two operand registers times two, truncated to 32 bits; operands 0x8000 and 0x8000 give 0x80000000.
- R3: Opcodes 9, 10 and 11 work as follows, and all three leave the flags unchanged.
  - Opcode 9 (multiply-load) clears the accumulator and loads `mul_x` and `mul_y` as the new operands.
  - Opcode 10 (multiply-add) adds the product held before the operation to the accumulator and loads new operands in the same cycle.
  - Opcode 11 (multiply-subtract) subtracts that same held product and likewise loads new operands.
- R4: Subtract (opcode 3) and add (opcode 5) use their operand as follows.
  - With source 0 or 3, the 16-bit data word is placed in bits 31:16 and bits 15:0 are zero.
  - Source 1 selects the 32-bit product, unshifted.
  - Source 2 selects the accumulator itself, unshifted.
- R5: Compare (opcode 4) forms the accumulator minus the operand, chosen as in R4. It updates the flags from that difference and leaves the accumulator unchanged.
- R6: The status word carries flags in four bits; all other bits read zero.
  - Bit 15 is N, a copy of bit 31 of the result.
  - Bit 14 is V.
  - Bit 13 is Z, set when the 32-bit result is zero.
  - Bit 12 is L.
  - Subtract, compare, add and the modifiers update Z and N and clear L and V.
- R7: Load-high (opcode 1) writes the data word into bits 31:16 and keeps bits 15:0. Load-full (opcode 2) writes the R4 operand into the whole accumulator. Neither load changes any flag.
- R8: AND (opcode 6), OR (opcode 7) and XOR (opcode 8) work as follows, and all three update Z and N from the full 32-bit result.
  - With a 16-bit source, they combine only bits 31:16 with the data word and keep bits 15:0.
  - With source 1 or 2, they act on all 32 bits.
- R9: The modifier (opcode 12) picks its action with the source field.
  - 0 is an arithmetic shift right by one.
  - 1 is a shift left by one.
  - 2 is negate.
  - 3 is absolute value, which negates only a negative accumulator, so 0x80000000 stays 0x80000000.
- R10: `cond_true` is combinational from the current flags.
  - Selector 0 is always true.
  - Selector 1 is true when Z equals `cond_pol`.
  - Selector 2 is true when N equals `cond_pol`.
  - Selector 3 is never true.
- R11: Two cases leave the accumulator, the product and the status unchanged: a cycle with `op_valid` low, and an operation with opcode 0, 13, 14 or 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | Operation strobe; the operation executes at this clock edge |
| op_code | input | 4 | Operation code |
| op_src | input | 2 | Operand source selector, or modifier selector for opcode 12 |
| op_data | input | 16 | 16-bit data operand |
| mul_x | input | 16 | New first multiplier operand |
| mul_y | input | 16 | New second multiplier operand |
| cond_sel | input | 2 | Condition selector |
| cond_pol | input | 1 | Polarity that the selected flag is compared with |
| acc_out | output | 32 | Accumulator |
| prod_out | output | 32 | Doubled product of the operand registers |
| status_out | output | 16 | Status word holding the flags |
| cond_true | output | 1 | Condition evaluation result |

## Verification
The bench builds the block with its default width of 16. At that width the product corner cases come within reach with a few operations. The two most negative operands give 0x80000000, and a negative-by-positive product sign-extends across all 32 bits. The accumulator edges are also reachable this way:

- absolute value of the most negative accumulator;
- a shift left that carries out the only set bit and raises Z;
- a 16-bit logic operation that clears the upper half while a nonzero lower half keeps Z low.

Each of these has a hand-computed expected value.

// File: rtl/fxmac_pkg.sv
package fxmac_pkg;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LDH  = 4'd1,
    OP_LDF  = 4'd2,
    OP_SUB  = 4'd3,
    OP_CMP  = 4'd4,
    OP_ADD  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_MLD  = 4'd9,
    OP_MPYA = 4'd10,
    OP_MPYS = 4'd11,
    OP_MOD  = 4'd12
  } fx_op_e;

  typedef enum logic [1:0] {
    CND_ALWAYS = 2'd0,
    CND_ZERO   = 2'd1,
    CND_NEG    = 2'd2,
    CND_NEVER  = 2'd3
  } fx_cond_e;

  localparam logic [1:0] SRC_DATA = 2'b00;
  localparam logic [1:0] SRC_PROD = 2'b01;
  localparam logic [1:0] SRC_ACC  = 2'b10;

  localparam logic [1:0] MOD_ASR = 2'd0;
  localparam logic [1:0] MOD_SHL = 2'd1;
  localparam logic [1:0] MOD_NEG = 2'd2;
  localparam logic [1:0] MOD_ABS = 2'd3;

  // index of each flag inside the 4-bit flag register
  localparam int FLG_L = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_V = 2;
  localparam int FLG_N = 3;

endpackage

// File: rtl/fxmac_mult.sv
module fxmac_mult #(
  parameter int DW = 16,
  localparam int AW = 2 * DW
) (
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [AW-1:0] prod
);

  // signed product, doubled for the fractional format
  function automatic logic [AW-1:0] frac_mul(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic signed [AW-1:0] full;
    full = AW'($signed(a)) * AW'($signed(b));
    return {full[AW-2:0], 1'b0};
  endfunction

  assign prod = frac_mul(opa, opb);

endmodule

// File: rtl/fxmac_alu.sv
module fxmac_alu
  import fxmac_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW = 2 * DW
) (
  input  fx_op_e        code,
  input  logic [1:0]    src,
  input  logic [DW-1:0] data,
  input  logic [AW-1:0] acc,
  input  logic [AW-1:0] prod,
  output logic [AW-1:0] acc_nxt,
  output logic [AW-1:0] flag_res,
  output logic          acc_we,
  output logic          mul_we,
  output logic          zn_we,
  output logic          lv_clr
);

  function automatic logic [AW-1:0] align_hi(input logic [DW-1:0] d);
    return {d, {DW{1'b0}}};
  endfunction

  function automatic logic [AW-1:0] modify(input logic [AW-1:0] a, input logic [1:0] m);
    case (m)
      MOD_ASR: return {a[AW-1], a[AW-1:1]};
      MOD_SHL: return {a[AW-2:0], 1'b0};
      MOD_NEG: return (~a) + AW'(1);
      default: return a[AW-1] ? ((~a) + AW'(1)) : a;
    endcase
  endfunction

  function automatic logic [AW-1:0] bitwise(input fx_op_e k, input logic [AW-1:0] a,
                                            input logic [AW-1:0] b, input logic hi_only);
    logic [AW-1:0] r;
    case (k)
      OP_AND:  r = a & b;
      OP_OR:   r = a | b;
      default: r = a ^ b;
    endcase
    if (hi_only) r[DW-1:0] = a[DW-1:0];
    return r;
  endfunction

  logic          src16;
  logic [AW-1:0] opnd;

  assign src16 = (src == SRC_DATA) || (src == 2'b11);

  always_comb begin
    if (src == SRC_PROD)     opnd = prod;
    else if (src == SRC_ACC) opnd = acc;
    else                     opnd = align_hi(data);
  end

  always_comb begin
    acc_nxt  = acc;
    flag_res = acc;
    acc_we   = 1'b0;
    mul_we   = 1'b0;
    zn_we    = 1'b0;
    lv_clr   = 1'b0;
    case (code)
      OP_LDH: begin
        acc_nxt = {data, acc[DW-1:0]};
        acc_we  = 1'b1;
      end
      OP_LDF: begin
        acc_nxt = opnd;
        acc_we  = 1'b1;
      end
      OP_SUB, OP_ADD: begin
        acc_nxt  = (code == OP_ADD) ? (acc + opnd) : (acc - opnd);
        flag_res = acc_nxt;
        acc_we   = 1'b1;
        zn_we    = 1'b1;
        lv_clr   = 1'b1;
      end
      OP_CMP: begin
        flag_res = acc - opnd;
        zn_we    = 1'b1;
        lv_clr   = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        acc_nxt  = bitwise(code, acc, opnd, src16);
        flag_res = acc_nxt;
        acc_we   = 1'b1;
        zn_we    = 1'b1;
      end
      OP_MLD: begin
        acc_nxt = '0;
        acc_we  = 1'b1;
        mul_we  = 1'b1;
      end
      OP_MPYA, OP_MPYS: begin
        acc_nxt = (code == OP_MPYA) ? (acc + prod) : (acc - prod);
        acc_we  = 1'b1;
        mul_we  = 1'b1;
      end
      OP_MOD: begin
        acc_nxt  = modify(acc, src);
        flag_res = acc_nxt;
        acc_we   = 1'b1;
        zn_we    = 1'b1;
        lv_clr   = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/fxmac_cond.sv
module fxmac_cond
  import fxmac_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       pol,
  input  logic       flag_z,
  input  logic       flag_n,
  output logic       hit
);

  always_comb begin
    case (fx_cond_e'(sel))
      CND_ALWAYS: hit = 1'b1;
      CND_ZERO:   hit = (flag_z == pol);
      CND_NEG:    hit = (flag_n == pol);
      default:    hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/fxmac_datapath.sv
module fxmac_datapath
  import fxmac_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_code,
  input  logic [1:0]    op_src,
  input  logic [DW-1:0] op_data,
  input  logic [DW-1:0] mul_x,
  input  logic [DW-1:0] mul_y,
  input  logic [1:0]    cond_sel,
  input  logic          cond_pol,
  output logic [AW-1:0] acc_out,
  output logic [AW-1:0] prod_out,
  output logic [DW-1:0] status_out,
  output logic          cond_true
);

  logic [AW-1:0] acc_q;
  logic [DW-1:0] x_q, y_q;
  logic [3:0]    flg_q;
  logic [AW-1:0] prod_w, acc_nxt, flag_res;
  logic          acc_we, mul_we, zn_we, lv_clr;

  // named events for the checker
  logic acc_load, opnd_load, zn_load, lv_wipe;
  assign acc_load  = op_valid & acc_we;
  assign opnd_load = op_valid & mul_we;
  assign zn_load   = op_valid & zn_we;
  assign lv_wipe   = op_valid & lv_clr;

  fxmac_mult #(.DW(DW)) u_mult (
    .opa (x_q),
    .opb (y_q),
    .prod(prod_w)
  );

  fxmac_alu #(.DW(DW)) u_alu (
    .code    (fx_op_e'(op_code)),
    .src     (op_src),
    .data    (op_data),
    .acc     (acc_q),
    .prod    (prod_w),
    .acc_nxt (acc_nxt),
    .flag_res(flag_res),
    .acc_we  (acc_we),
    .mul_we  (mul_we),
    .zn_we   (zn_we),
    .lv_clr  (lv_clr)
  );

  fxmac_cond u_cond (
    .sel   (cond_sel),
    .pol   (cond_pol),
    .flag_z(flg_q[FLG_Z]),
    .flag_n(flg_q[FLG_N]),
    .hit   (cond_true)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      x_q   <= '0;
      y_q   <= '0;
      flg_q <= '0;
    end else begin
      if (acc_load) acc_q <= acc_nxt;
      if (opnd_load) begin
        x_q <= mul_x;
        y_q <= mul_y;
      end
      if (zn_load) begin
        flg_q[FLG_Z] <= ~|flag_res;
        flg_q[FLG_N] <= flag_res[AW-1];
      end
      if (lv_wipe) begin
        flg_q[FLG_L] <= 1'b0;
        flg_q[FLG_V] <= 1'b0;
      end
    end
  end

  assign acc_out    = acc_q;
  assign prod_out   = prod_w;
  assign status_out = {flg_q[FLG_N], flg_q[FLG_V], flg_q[FLG_Z], flg_q[FLG_L], {(DW-4){1'b0}}};

endmodule

// File: rtl/fxmac_chk.sv
module fxmac_chk
  import fxmac_pkg::*;
#(
  parameter int DW = 16,
  localparam int AW = 2 * DW
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic [3:0]    op_code,
  input logic [DW-1:0] mul_x,
  input logic [DW-1:0] mul_y,
  input logic [1:0]    cond_sel,
  input logic [AW-1:0] acc_out,
  input logic [AW-1:0] prod_out,
  input logic [DW-1:0] status_out,
  input logic          cond_true,
  input logic          zn_load,
  input logic          lv_wipe
);

  logic signed [AW-1:0] raw_prod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_prod_q <= '0;
    else if (op_valid && op_code == OP_MLD)
      raw_prod_q <= AW'($signed(mul_x)) * AW'($signed(mul_y));
  end

  // R2
  mld_product_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_MLD) |=> (prod_out == {raw_prod_q[AW-2:0], 1'b0}));

  // R3
  mld_clears_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_MLD) |=> (acc_out == '0));

  // R5
  cmp_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_CMP) |=> $stable(acc_out));

  // R6
  zn_tracks_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_ADD || op_code == OP_SUB || op_code == OP_MOD))
    |=> (status_out[DW-3] == (acc_out == '0)) && (status_out[DW-1] == acc_out[AW-1]));

  // R6
  lv_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lv_wipe |=> (status_out[DW-2] == 1'b0) && (status_out[DW-4] == 1'b0));

  // R6
  status_spare_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_out[DW-5:0] == '0);

  // R7
  load_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_LDH || op_code == OP_LDF)) |=> $stable(status_out));

  // R10
  cond_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == CND_ALWAYS) |-> cond_true);

  // R10
  cond_never_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_sel == CND_NEVER) |-> !cond_true);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(acc_out) && $stable(prod_out) && $stable(status_out)));

  // R11
  no_flag_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!zn_load && !lv_wipe) |=> $stable(status_out));

endmodule

bind fxmac_datapath fxmac_chk #(.DW(DW)) u_fxmac_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_valid  (op_valid),
  .op_code   (op_code),
  .mul_x     (mul_x),
  .mul_y     (mul_y),
  .cond_sel  (cond_sel),
  .acc_out   (acc_out),
  .prod_out  (prod_out),
  .status_out(status_out),
  .cond_true (cond_true),
  .zn_load   (zn_load),
  .lv_wipe   (lv_wipe)
);

// File: tb/test_fxmac_datapath.sv
module test_fxmac_datapath;
  import fxmac_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [3:0]    op_code = 4'd0;
  logic [1:0]    op_src = 2'd0;
  logic [DW-1:0] op_data = '0;
  logic [DW-1:0] mul_x = '0;
  logic [DW-1:0] mul_y = '0;
  logic [1:0]    cond_sel = 2'd0;
  logic          cond_pol = 1'b0;
  logic [AW-1:0] acc_out, prod_out;
  logic [DW-1:0] status_out;
  logic          cond_true;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fxmac_datapath #(.DW(DW)) i_fxmac_datapath (
    .clk, .rst_n, .op_valid, .op_code, .op_src, .op_data, .mul_x, .mul_y,
    .cond_sel, .cond_pol, .acc_out, .prod_out, .status_out, .cond_true
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] c, input logic [1:0] s, input logic [15:0] d,
                        input logic [15:0] x = 16'h0, input logic [15:0] y = 16'h0);
    @(negedge clk);
    op_valid = 1'b1; op_code = c; op_src = s; op_data = d; mul_x = x; mul_y = y;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic expect_state(input string tag, input logic [31:0] a, input logic [15:0] st);
    check({tag, " acc"}, acc_out, a);
    check({tag, " status"}, {16'h0, status_out}, {16'h0, st});
  endtask

  task automatic cond_probe(input string tag, input logic [1:0] s, input logic p, input logic exp);
    cond_sel = s; cond_pol = p;
    #1;
    check(tag, {31'h0, cond_true}, {31'h0, exp});
  endtask

  task automatic t_reset;
    expect_state("R1 reset", 32'h0, 16'h0);
    check("R1 reset prod", prod_out, 32'h0);
    cond_probe("R10 reset always", 2'd0, 1'b0, 1'b1);
    cond_probe("R10 reset Z==0", 2'd1, 1'b0, 1'b1);
    cond_probe("R10 reset Z==1", 2'd1, 1'b1, 1'b0);
  endtask

  task automatic t_mult;
    run_op(OP_MLD, 2'd0, 16'h0, 16'd3, 16'd5);
    check("R2 3*5*2", prod_out, 32'd30);
    check("R3 mld acc", acc_out, 32'h0);
    run_op(OP_MLD, 2'd0, 16'h0, 16'hFFFE, 16'd7);
    check("R2 -2*7*2", prod_out, 32'hFFFFFFE4);
    run_op(OP_MLD, 2'd0, 16'h0, 16'h8000, 16'h8000);
    check("R2 min*min", prod_out, 32'h80000000);
  endtask

  task automatic t_mac;
    run_op(OP_MLD, 2'd0, 16'h0, 16'd3, 16'd4);
    check("R3 mld P", prod_out, 32'd24);
    run_op(OP_MPYA, 2'd0, 16'h0, 16'd5, 16'd6);
    check("R3 mpya acc", acc_out, 32'd24);
    check("R3 mpya P", prod_out, 32'd60);
    run_op(OP_MPYA, 2'd0, 16'h0, 16'd1, 16'd1);
    check("R3 mpya2 acc", acc_out, 32'd84);
    run_op(OP_MPYS, 2'd0, 16'h0, 16'd0, 16'd0);
    check("R3 mpys acc", acc_out, 32'd82);
    check("R3 mpys P", prod_out, 32'd0);
    check("R3 flags untouched", {16'h0, status_out}, 32'h0);
  endtask

  task automatic t_arith;
    run_op(OP_MLD, 2'd0, 16'h0, 16'd1, 16'd1);
    run_op(OP_LDF, SRC_DATA, 16'h0001);
    expect_state("R4 ldf data", 32'h00010000, 16'h0000);
    run_op(OP_ADD, SRC_DATA, 16'h0002);
    expect_state("R4 add data", 32'h00030000, 16'h0000);
    run_op(OP_SUB, SRC_DATA, 16'h0003);
    expect_state("R6 sub to zero", 32'h00000000, 16'h2000);
    run_op(OP_SUB, 2'b11, 16'h0001);
    expect_state("R6 sub negative", 32'hFFFF0000, 16'h8000);
    run_op(OP_ADD, SRC_PROD, 16'h7777);
    expect_state("R4 add P", 32'hFFFF0002, 16'h8000);
    run_op(OP_ADD, SRC_ACC, 16'h0);
    expect_state("R4 add A", 32'hFFFE0004, 16'h8000);
    run_op(OP_SUB, SRC_PROD, 16'h0);
    expect_state("R4 sub P", 32'hFFFE0002, 16'h8000);
  endtask

  task automatic t_cmp;
    run_op(OP_LDF, SRC_DATA, 16'h0005);
    expect_state("R7 ldf keeps flags", 32'h00050000, 16'h8000);
    run_op(OP_CMP, SRC_DATA, 16'h0005);
    expect_state("R5 cmp equal", 32'h00050000, 16'h2000);
    run_op(OP_CMP, SRC_DATA, 16'h0006);
    expect_state("R5 cmp less", 32'h00050000, 16'h8000);
    run_op(OP_CMP, SRC_ACC, 16'h0);
    expect_state("R5 cmp self", 32'h00050000, 16'h2000);
  endtask

  task automatic t_load;
    run_op(OP_LDH, SRC_PROD, 16'h1234);
    expect_state("R7 ldh", 32'h12340000, 16'h2000);
    run_op(OP_LDF, SRC_PROD, 16'h0);
    expect_state("R7 ldf P", 32'h00000002, 16'h2000);
    run_op(OP_LDH, SRC_DATA, 16'hABCD);
    expect_state("R7 ldh keeps low", 32'hABCD0002, 16'h2000);
  endtask

  task automatic t_logic;
    run_op(OP_MLD, 2'd0, 16'h0, 16'h091A, 16'd1);
    check("R2 P 0x1234", prod_out, 32'h00001234);
    run_op(OP_LDF, SRC_PROD, 16'h0);
    run_op(OP_LDH, SRC_DATA, 16'h0F0F);
    run_op(OP_AND, SRC_DATA, 16'h00FF);
    expect_state("R8 and16", 32'h000F1234, 16'h0000);
    run_op(OP_XOR, SRC_DATA, 16'h000F);
    expect_state("R8 xor16 low kept", 32'h00001234, 16'h0000);
    run_op(OP_OR, SRC_DATA, 16'h8000);
    expect_state("R8 or16", 32'h80001234, 16'h8000);
    run_op(OP_AND, SRC_PROD, 16'h0);
    expect_state("R8 and32 P", 32'h00001234, 16'h0000);
    run_op(OP_XOR, SRC_ACC, 16'h0);
    expect_state("R8 xor32 A", 32'h00000000, 16'h2000);
  endtask

  task automatic t_modify;
    run_op(OP_LDF, SRC_DATA, 16'h8000);
    run_op(OP_MOD, MOD_ASR, 16'h0);
    expect_state("R9 asr", 32'hC0000000, 16'h8000);
    run_op(OP_MOD, MOD_SHL, 16'h0);
    expect_state("R9 shl", 32'h80000000, 16'h8000);
    run_op(OP_MOD, MOD_ABS, 16'h0);
    expect_state("R9 abs min", 32'h80000000, 16'h8000);
    run_op(OP_MOD, MOD_SHL, 16'h0);
    expect_state("R9 shl out", 32'h00000000, 16'h2000);
    run_op(OP_LDF, SRC_DATA, 16'hFFFF);
    run_op(OP_MOD, MOD_ABS, 16'h0);
    expect_state("R9 abs neg", 32'h00010000, 16'h0000);
    run_op(OP_MOD, MOD_ABS, 16'h0);
    expect_state("R9 abs pos", 32'h00010000, 16'h0000);
    run_op(OP_MOD, MOD_NEG, 16'h0);
    expect_state("R9 neg", 32'hFFFF0000, 16'h8000);
    run_op(OP_MOD, MOD_ASR, 16'h0);
    expect_state("R9 asr neg", 32'hFFFF8000, 16'h8000);
  endtask

  task automatic t_cond;
    run_op(OP_XOR, SRC_ACC, 16'h0);
    cond_probe("R10 Z==1 on zero", 2'd1, 1'b1, 1'b1);
    cond_probe("R10 Z==0 on zero", 2'd1, 1'b0, 1'b0);
    cond_probe("R10 N==0 on zero", 2'd2, 1'b0, 1'b1);
    cond_probe("R10 N==1 on zero", 2'd2, 1'b1, 1'b0);
    cond_probe("R10 never", 2'd3, 1'b1, 1'b0);
    cond_probe("R10 always", 2'd0, 1'b1, 1'b1);
    run_op(OP_SUB, SRC_DATA, 16'h0001);
    cond_probe("R10 N==1 on neg", 2'd2, 1'b1, 1'b1);
    cond_probe("R10 Z==1 on neg", 2'd1, 1'b1, 1'b0);
  endtask

  task automatic t_ignored;
    logic [31:0] a0, p0;
    logic [15:0] s0;
    a0 = acc_out; p0 = prod_out; s0 = status_out;
    @(negedge clk);
    op_valid = 1'b0; op_code = OP_MLD; op_src = SRC_DATA; op_data = 16'h0055;
    mul_x = 16'h0101; mul_y = 16'h0202;
    @(negedge clk);
    expect_state("R11 idle", a0, s0);
    check("R11 idle prod", prod_out, p0);
    for (int c = 13; c <= 15; c++) begin
      run_op(4'(c), SRC_DATA, 16'h1111, 16'h0003, 16'h0003);
      expect_state("R11 undefined op", a0, s0);
      check("R11 undefined op prod", prod_out, p0);
    end
    run_op(OP_NOP, SRC_ACC, 16'h1111, 16'h0003, 16'h0003);
    expect_state("R11 nop", a0, s0);
    check("R11 nop prod", prod_out, p0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mult();
    t_mac();
    t_arith();
    t_cmp();
    t_load();
    t_logic();
    t_modify();
    t_cond();
    t_ignored();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule